// File: doc/BRIEF.md
# Taint-Shadow Gate Library with Ripple Adder

This block is a combinational library of shadow gates for tracking untrusted or secret data at the level of single bits. Every data bit is paired with a tag bit. Each shadow gate produces its ordinary logic output. It also produces an output tag, which is raised only when a tagged input can, for the given untagged input values, change that output. The primitives are inversion, two-input AND, OR and NAND, an XOR built from four NANDs, and a 2:1 selector offered in two forms.

The first selector form is the plain composition of its gate shadows. It is sound but flags the output whenever a tagged select can pass through, including the case where both data inputs are 1 and carry no tag. The second form adds the redundant consensus product of the two data inputs before the shadows are wired. That extra product makes the selector's tag exact.

The top level exposes one selector lane and a ripple-carry adder built gate by gate from the library. Each adder stage forms its carry with the selector: when the two operand bits differ the carry-in is passed, otherwise the operand bit is passed. A parameter picks which selector form is used, so the tag precision of the two composition styles can be compared on the same arithmetic.

Top module: `taint_adder`

## Requirements
- R1: `add_s` and `add_co` equal the low WIDTH bits and the carry of `add_a + add_b + add_ci`, and `mx_y` equals `mx_d1` when `mx_sel` is 1 and `mx_d0` otherwise, whatever the tags.
- R2: The AND and NAND shadows raise the output tag exactly when `a·bt + b·at + at·bt` is 1. For example, NAND with a=0 untagged and b=1 tagged gives output 1 untagged.
- R3: The OR shadow raises its tag exactly when `~a·bt + ~b·at + at·bt` is 1, and the inverter passes its input tag unchanged.
- R4: With PRECISE_MUX=1 the selector tag is 1 exactly when some assignment of the tagged inputs among {d0, d1, sel} changes `mx_y`. A tag on the unselected data input under an untagged select therefore has no effect.
- R5: With sel tagged and d0=d1=1 untagged, the precise selector gives an untagged output and the compositional selector (PRECISE_MUX=0) gives a tagged output.
- R6: When every input tag is 0, every output tag is 0 in both variants.
- R7: In both variants, every adder and selector output bit that some assignment of the tagged inputs can change has its tag set. In particular, a tag on `add_a[0]` always tags `add_s[0]`.
- R8: For the same data and tags, every output tag set by the precise adder is also set by the compositional adder. Over all inputs, the precise adder tags `add_co` in strictly fewer cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| add_a | input | WIDTH | Adder operand A |
| add_a_tg | input | WIDTH | Per-bit tags of operand A |
| add_b | input | WIDTH | Adder operand B |
| add_b_tg | input | WIDTH | Per-bit tags of operand B |
| add_ci | input | 1 | Adder carry-in |
| add_ci_tg | input | 1 | Tag of the carry-in |
| add_s | output | WIDTH | Sum bits |
| add_s_tg | output | WIDTH | Per-bit tags of the sum |
| add_co | output | 1 | Carry-out |
| add_co_tg | output | 1 | Tag of the carry-out |
| mx_d0 | input | 1 | Selector data input chosen when sel=0 |
| mx_d0_tg | input | 1 | Tag of mx_d0 |
| mx_d1 | input | 1 | Selector data input chosen when sel=1 |
| mx_d1_tg | input | 1 | Tag of mx_d1 |
| mx_sel | input | 1 | Selector control |
| mx_sel_tg | input | 1 | Tag of the selector control |
| mx_y | output | 1 | Selector output |
| mx_y_tg | output | 1 | Tag of the selector output |

## Verification
The bench builds two copies at the default WIDTH of 4, one with PRECISE_MUX=1 and one with PRECISE_MUX=0, and drives them with identical stimulus. With only nine data bits and nine tag bits at that width, every data and tag combination of the adder is swept against a reference that flips the tagged inputs through all values. The same reference is applied exhaustively to each gate and to the selector. Running the two variants together makes the per-vector subset relation and the carry-out count gap between composition styles directly observable.

// File: rtl/taint_pkg.sv
package taint_pkg;
   // One data bit paired with its tag.
   typedef struct packed {
      logic v;
      logic t;
   } tbit_t;
endpackage

// File: rtl/taint_gates.sv
module tg_not
   import taint_pkg::*;
(
   input  tbit_t a,
   output tbit_t y
);
   assign y.v = ~a.v;
   assign y.t = a.t;
endmodule

module tg_and
   import taint_pkg::*;
(
   input  tbit_t a,
   input  tbit_t b,
   output tbit_t y
);
   assign y.v = a.v & b.v;
   // a tagged input matters only if the other side does not force 0
   assign y.t = (a.v & b.t) | (b.v & a.t) | (a.t & b.t);
endmodule

module tg_nand
   import taint_pkg::*;
(
   input  tbit_t a,
   input  tbit_t b,
   output tbit_t y
);
   assign y.v = ~(a.v & b.v);
   assign y.t = (a.v & b.t) | (b.v & a.t) | (a.t & b.t);
endmodule

module tg_or
   import taint_pkg::*;
(
   input  tbit_t a,
   input  tbit_t b,
   output tbit_t y
);
   assign y.v = a.v | b.v;
   // a tagged input matters only if the other side does not force 1
   assign y.t = (~a.v & b.t) | (~b.v & a.t) | (a.t & b.t);
endmodule

// XOR composed from four NAND shadows
module tg_xor
   import taint_pkg::*;
(
   input  tbit_t a,
   input  tbit_t b,
   output tbit_t y
);
   tbit_t n_ab, n_a, n_b;

   tg_nand u_n0 (.a(a),   .b(b),    .y(n_ab));
   tg_nand u_n1 (.a(a),   .b(n_ab), .y(n_a));
   tg_nand u_n2 (.a(b),   .b(n_ab), .y(n_b));
   tg_nand u_n3 (.a(n_a), .b(n_b),  .y(y));
endmodule

// File: rtl/taint_mux.sv
module tg_mux
   import taint_pkg::*;
#(
   parameter int PRECISE = 0
) (
   input  tbit_t d0,
   input  tbit_t d1,
   input  tbit_t sel,
   output tbit_t y
);
   tbit_t sel_n, pick0, pick1, pick_or;

   if (PRECISE != 0 && PRECISE != 1) begin : g_bad_mode
      $error("tg_mux: PRECISE must be 0 or 1");
   end

   tg_not u_inv  (.a(sel),   .y(sel_n));
   tg_and u_p0   (.a(sel_n), .b(d0),    .y(pick0));
   tg_and u_p1   (.a(sel),   .b(d1),    .y(pick1));
   tg_or  u_join (.a(pick0), .b(pick1), .y(pick_or));

   if (PRECISE == 1) begin : g_consensus
      tbit_t both;
      // redundant d0&d1 product: hides a tagged select when inputs agree at 1
      tg_and u_cons (.a(d0),      .b(d1),   .y(both));
      tg_or  u_fold (.a(pick_or), .b(both), .y(y));
   end else begin : g_plain
      assign y = pick_or;
   end
endmodule

// File: rtl/taint_fa.sv
module tg_full_add
   import taint_pkg::*;
#(
   parameter int PRECISE_MUX = 0
) (
   input  tbit_t a,
   input  tbit_t b,
   input  tbit_t ci,
   output tbit_t s,
   output tbit_t co
);
   tbit_t prop;

   tg_xor u_x0 (.a(a),    .b(b),  .y(prop));
   tg_xor u_x1 (.a(prop), .b(ci), .y(s));

   // carry: propagate passes ci, otherwise a==b so b is the carry
   tg_mux #(.PRECISE(PRECISE_MUX)) u_cy (
      .d0 (b),
      .d1 (ci),
      .sel(prop),
      .y  (co)
   );
endmodule

// File: rtl/taint_adder.sv
module taint_adder
   import taint_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int PRECISE_MUX = 1
) (
   input  logic [WIDTH-1:0] add_a,
   input  logic [WIDTH-1:0] add_a_tg,
   input  logic [WIDTH-1:0] add_b,
   input  logic [WIDTH-1:0] add_b_tg,
   input  logic             add_ci,
   input  logic             add_ci_tg,
   output logic [WIDTH-1:0] add_s,
   output logic [WIDTH-1:0] add_s_tg,
   output logic             add_co,
   output logic             add_co_tg,
   input  logic             mx_d0,
   input  logic             mx_d0_tg,
   input  logic             mx_d1,
   input  logic             mx_d1_tg,
   input  logic             mx_sel,
   input  logic             mx_sel_tg,
   output logic             mx_y,
   output logic             mx_y_tg
);
   localparam int CHAIN = WIDTH + 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("taint_adder: WIDTH must be at least 1");
   end
   if (PRECISE_MUX != 0 && PRECISE_MUX != 1) begin : g_bad_mode
      $error("taint_adder: PRECISE_MUX must be 0 or 1");
   end

   tbit_t op_a [WIDTH];
   tbit_t op_b [WIDTH];
   tbit_t sm   [WIDTH];
   tbit_t cy   [CHAIN];

   assign cy[0].v = add_ci;
   assign cy[0].t = add_ci_tg;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      assign op_a[i].v = add_a[i];
      assign op_a[i].t = add_a_tg[i];
      assign op_b[i].v = add_b[i];
      assign op_b[i].t = add_b_tg[i];

      tg_full_add #(.PRECISE_MUX(PRECISE_MUX)) u_fa (
         .a (op_a[i]),
         .b (op_b[i]),
         .ci(cy[i]),
         .s (sm[i]),
         .co(cy[i+1])
      );

      assign add_s[i]    = sm[i].v;
      assign add_s_tg[i] = sm[i].t;
   end

   assign add_co    = cy[WIDTH].v;
   assign add_co_tg = cy[WIDTH].t;

   // standalone selector lane
   tbit_t m0, m1, ms, my;
   assign m0 = '{v: mx_d0,  t: mx_d0_tg};
   assign m1 = '{v: mx_d1,  t: mx_d1_tg};
   assign ms = '{v: mx_sel, t: mx_sel_tg};

   tg_mux #(.PRECISE(PRECISE_MUX)) u_lane (
      .d0 (m0),
      .d1 (m1),
      .sel(ms),
      .y  (my)
   );

   assign mx_y    = my.v;
   assign mx_y_tg = my.t;
endmodule

module taint_adder_chk #(
   parameter int WIDTH       = 4,
   parameter int PRECISE_MUX = 1
) (
   input logic [WIDTH-1:0] add_a,
   input logic [WIDTH-1:0] add_a_tg,
   input logic [WIDTH-1:0] add_b,
   input logic [WIDTH-1:0] add_b_tg,
   input logic             add_ci,
   input logic             add_ci_tg,
   input logic [WIDTH-1:0] add_s,
   input logic [WIDTH-1:0] add_s_tg,
   input logic             add_co,
   input logic             add_co_tg,
   input logic             mx_d0,
   input logic             mx_d0_tg,
   input logic             mx_d1,
   input logic             mx_d1_tg,
   input logic             mx_sel,
   input logic             mx_sel_tg,
   input logic             mx_y,
   input logic             mx_y_tg
);
   logic [WIDTH:0] want_sum;
   logic           in_known;

   assign want_sum = {1'b0, add_a} + {1'b0, add_b} + (WIDTH+1)'(add_ci);
   assign in_known = !$isunknown({add_a, add_a_tg, add_b, add_b_tg, add_ci,
                                  add_ci_tg, mx_d0, mx_d0_tg, mx_d1, mx_d1_tg,
                                  mx_sel, mx_sel_tg});

   always_comb begin
      if (in_known) begin
         // R1
         sum_value_chk: assert ({add_co, add_s} == want_sum);
         // R1
         mux_value_chk: assert (mx_y == (mx_sel ? mx_d1 : mx_d0));
         // R6
         adder_clean_chk: assert ((add_a_tg != '0) || (add_b_tg != '0) || add_ci_tg
                                  || ((add_s_tg == '0) && !add_co_tg));
         // R6
         mux_clean_chk: assert (mx_d0_tg || mx_d1_tg || mx_sel_tg || !mx_y_tg);
         // R4
         mux_unselected_chk: assert (mx_sel_tg
                                     || (mx_y_tg == (mx_sel ? mx_d1_tg : mx_d0_tg)));
         // R7
         mux_sel_visible_chk: assert (!(mx_sel_tg && (mx_d0 != mx_d1)) || mx_y_tg);
         // R7
         lsb_sum_tag_chk: assert (!add_a_tg[0] || add_s_tg[0]);
         // R5
         mux_consensus_chk: assert (!((PRECISE_MUX == 1) && mx_sel_tg && !mx_d0_tg
                                      && !mx_d1_tg && mx_d0 && mx_d1) || !mx_y_tg);
         // R5
         mux_false_pos_chk: assert (!((PRECISE_MUX == 0) && mx_sel_tg && !mx_d0_tg
                                      && !mx_d1_tg && mx_d0 && mx_d1) || mx_y_tg);
      end
   end
endmodule

bind taint_adder taint_adder_chk #(.WIDTH(WIDTH), .PRECISE_MUX(PRECISE_MUX)) u_chk (
   .add_a(add_a), .add_a_tg(add_a_tg), .add_b(add_b), .add_b_tg(add_b_tg),
   .add_ci(add_ci), .add_ci_tg(add_ci_tg), .add_s(add_s), .add_s_tg(add_s_tg),
   .add_co(add_co), .add_co_tg(add_co_tg), .mx_d0(mx_d0), .mx_d0_tg(mx_d0_tg),
   .mx_d1(mx_d1), .mx_d1_tg(mx_d1_tg), .mx_sel(mx_sel), .mx_sel_tg(mx_sel_tg),
   .mx_y(mx_y), .mx_y_tg(mx_y_tg)
);

// File: tb/taint_adder_test.sv
module taint_adder_test;
   import taint_pkg::*;

   localparam int W = 4;
   localparam int NIN = 2*W + 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   logic [W-1:0] a, at, b, bt;
   logic ci, cit;
   logic d0, d0t, d1, d1t, s, st;

   logic [W-1:0] sp, spt, sc, sct;
   logic cop, copt, coc, coct;
   logic yp, ypt, yc, yct;

   taint_adder #(.WIDTH(W), .PRECISE_MUX(1)) uut (
      .add_a(a), .add_a_tg(at), .add_b(b), .add_b_tg(bt),
      .add_ci(ci), .add_ci_tg(cit), .add_s(sp), .add_s_tg(spt),
      .add_co(cop), .add_co_tg(copt),
      .mx_d0(d0), .mx_d0_tg(d0t), .mx_d1(d1), .mx_d1_tg(d1t),
      .mx_sel(s), .mx_sel_tg(st), .mx_y(yp), .mx_y_tg(ypt));

   taint_adder #(.WIDTH(W), .PRECISE_MUX(0)) uut_cmp (
      .add_a(a), .add_a_tg(at), .add_b(b), .add_b_tg(bt),
      .add_ci(ci), .add_ci_tg(cit), .add_s(sc), .add_s_tg(sct),
      .add_co(coc), .add_co_tg(coct),
      .mx_d0(d0), .mx_d0_tg(d0t), .mx_d1(d1), .mx_d1_tg(d1t),
      .mx_sel(s), .mx_sel_tg(st), .mx_y(yc), .mx_y_tg(yct));

   tbit_t ga, gb, y_and, y_or, y_nand, y_not;
   tg_and  g_and  (.a(ga), .b(gb), .y(y_and));
   tg_or   g_or   (.a(ga), .b(gb), .y(y_or));
   tg_nand g_nand (.a(ga), .b(gb), .y(y_nand));
   tg_not  g_not  (.a(ga), .y(y_not));

   // {d0,d0t,d1,d1t,sel,selt,exp_y,exp_yt} for the precise selector
   localparam logic [7:0] MUX_VEC [8] = '{
      8'b10100110, 8'b00001100, 8'b00100101, 8'b11000011,
      8'b11001000, 8'b00111011, 8'b10110010, 8'b01111111
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   function automatic logic [W:0] add_fn(input logic [NIN-1:0] x);
      return {1'b0, x[W-1:0]} + {1'b0, x[2*W-1:W]} + (W+1)'(x[2*W]);
   endfunction

   // exact tag: bits that change for some assignment of the tagged inputs
   function automatic logic [W:0] add_ref(input logic [NIN-1:0] x,
                                          input logic [NIN-1:0] m);
      logic [W:0] r0, acc;
      logic [NIN-1:0] sub;
      r0 = add_fn(x); acc = '0; sub = m;
      for (int k = 0; k < (1 << NIN); k++) begin
         acc = acc | (add_fn((x & ~m) | sub) ^ r0);
         if (sub == '0) break;
         sub = (sub - 1'b1) & m;
      end
      return acc;
   endfunction

   // x = {sel,d1,d0}
   function automatic logic mux_fn(input logic [2:0] x);
      return x[2] ? x[1] : x[0];
   endfunction

   function automatic logic mux_ref(input logic [2:0] x, input logic [2:0] m);
      logic acc;
      acc = 1'b0;
      for (int k = 0; k < 8; k++)
         if ((k[2:0] & ~m) == 3'b000)
            acc = acc | (mux_fn((x & ~m) | k[2:0]) ^ mux_fn(x));
      return acc;
   endfunction

   // op 0 AND, 1 OR, 2 NAND, 3 NOT(a)
   function automatic logic gate_fn(input int op, input logic p, input logic q);
      case (op)
         0: return p & q;
         1: return p | q;
         2: return ~(p & q);
         default: return ~p;
      endcase
   endfunction

   function automatic logic gate_ref(input int op, input logic p, input logic pt,
                                     input logic q, input logic qt);
      logic acc;
      acc = 1'b0;
      for (int k = 0; k < 4; k++) begin
         logic pp, qq;
         pp = pt ? k[0] : p;
         qq = qt ? k[1] : q;
         acc = acc | (gate_fn(op, pp, qq) ^ gate_fn(op, p, q));
      end
      return acc;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
         finish_run();
      end
   end

   int cnt_p [W+1];
   int cnt_c [W+1];

   initial begin
      a = '0; at = '0; b = '0; bt = '0; ci = 0; cit = 0;
      d0 = 0; d0t = 0; d1 = 0; d1t = 0; s = 0; st = 0;
      ga = '0; gb = '0;
      for (int i = 0; i <= W; i++) begin cnt_p[i] = 0; cnt_c[i] = 0; end
      #2;

      // idle state: zero inputs, no tags
      chk({cop, sp, copt, spt, ypt} == '0, "R6", "idle outputs precise",
          {cop, sp, copt, spt, ypt}, 0);
      chk({coc, sc, coct, sct, yct} == '0, "R6", "idle outputs compositional",
          {coc, sc, coct, sct, yct}, 0);

      // selector table, precise variant
      foreach (MUX_VEC[i]) begin
         {d0, d0t, d1, d1t, s, st} = MUX_VEC[i][7:2];
         #1;
         chk(yp == MUX_VEC[i][1], "R1", $sformatf("mux vec %0d value", i),
             yp, MUX_VEC[i][1]);
         chk(ypt == MUX_VEC[i][0], "R4", $sformatf("mux vec %0d tag", i),
             ypt, MUX_VEC[i][0]);
      end

      // R5 consensus case on both variants
      {d0, d0t, d1, d1t, s, st} = 6'b101001;
      #1;
      chk(ypt == 1'b0, "R5", "precise sel-tag with d0=d1=1", ypt, 0);
      chk(yct == 1'b1, "R5", "compositional sel-tag with d0=d1=1", yct, 1);

      // R2 directed NAND: a=0 clean, b=1 tagged
      ga = '{v: 1'b0, t: 1'b0}; gb = '{v: 1'b1, t: 1'b1};
      #1;
      chk(y_nand.v == 1'b1 && y_nand.t == 1'b0, "R2", "nand a=0 b=1 bt",
          {y_nand.v, y_nand.t}, 2'b10);

      // exhaustive gate shadows
      for (int v = 0; v < 16; v++) begin
         ga = '{v: v[0], t: v[2]}; gb = '{v: v[1], t: v[3]};
         #1;
         chk(y_and.t == gate_ref(0, v[0], v[2], v[1], v[3]) && y_and.v == gate_fn(0, v[0], v[1]),
             "R2", $sformatf("and %0h", v), {y_and.v, y_and.t},
             {gate_fn(0, v[0], v[1]), gate_ref(0, v[0], v[2], v[1], v[3])});
         chk(y_nand.t == gate_ref(2, v[0], v[2], v[1], v[3]) && y_nand.v == gate_fn(2, v[0], v[1]),
             "R2", $sformatf("nand %0h", v), {y_nand.v, y_nand.t},
             {gate_fn(2, v[0], v[1]), gate_ref(2, v[0], v[2], v[1], v[3])});
         chk(y_or.t == gate_ref(1, v[0], v[2], v[1], v[3]) && y_or.v == gate_fn(1, v[0], v[1]),
             "R3", $sformatf("or %0h", v), {y_or.v, y_or.t},
             {gate_fn(1, v[0], v[1]), gate_ref(1, v[0], v[2], v[1], v[3])});
         chk(y_not.t == gate_ref(3, v[0], v[2], v[1], v[3]) && y_not.v == ~v[0],
             "R3", $sformatf("not %0h", v), {y_not.v, y_not.t},
             {~v[0], gate_ref(3, v[0], v[2], v[1], v[3])});
      end

      // exhaustive selector: exact for precise, sound for compositional
      for (int v = 0; v < 64; v++) begin
         logic [2:0] xv, mv;
         logic r;
         xv = v[2:0]; mv = v[5:3];
         {s, d1, d0} = xv; {st, d1t, d0t} = mv;
         #1;
         r = mux_ref(xv, mv);
         chk(ypt == r, "R4", $sformatf("precise mux x=%0h m=%0h", xv, mv), ypt, r);
         chk(!r || yct, "R7", $sformatf("compositional mux x=%0h m=%0h", xv, mv), yct, r);
         chk(yp == mux_fn(xv) && yc == mux_fn(xv), "R1",
             $sformatf("mux value x=%0h", xv), {yp, yc}, {2{mux_fn(xv)}});
      end

      // exhaustive adder: values, soundness, clean propagation, subset
      for (int xi = 0; xi < (1 << NIN); xi++) begin
         for (int mi = 0; mi < (1 << NIN); mi++) begin
            logic [NIN-1:0] x, m;
            logic [W:0] ev, et, gp, gc;
            x = xi[NIN-1:0]; m = mi[NIN-1:0];
            {ci, b, a} = x; {cit, bt, at} = m;
            #1;
            ev = add_fn(x);
            et = add_ref(x, m);
            gp = {copt, spt};
            gc = {coct, sct};
            chk({cop, sp} == ev && {coc, sc} == ev, "R1",
                $sformatf("sum x=%0h", x), {cop, sp}, ev);
            chk((et & ~gp) == '0 && (et & ~gc) == '0, "R7",
                $sformatf("sound x=%0h m=%0h", x, m), {gp, gc}, et);
            chk((gp & ~gc) == '0, "R8",
                $sformatf("subset x=%0h m=%0h", x, m), gp, gc);
            if (m == '0)
               chk(gp == '0 && gc == '0, "R6",
                   $sformatf("clean x=%0h", x), {gp, gc}, 0);
            for (int k = 0; k <= W; k++) begin
               cnt_p[k] += gp[k];
               cnt_c[k] += gc[k];
            end
         end
      end

      for (int k = 0; k <= W; k++)
         chk(cnt_p[k] <= cnt_c[k], "R8", $sformatf("tag count bit %0d", k),
             cnt_p[k], cnt_c[k]);
      chk(cnt_p[W] < cnt_c[W], "R8", "carry-out tag count strictly lower",
          cnt_p[W], cnt_c[W]);

      finish_run();
   end
endmodule